// File: doc/BRIEF.md
# Root Port Bridge Header Emulator

This block sits between a host configuration port and an indirect configuration router that feeds a PCIe root port. The root port hardware shows a non-conforming Type 0 header and places itself on the secondary bus as device 1. The block makes it look like a normal Type 1 bridge at bus 0, device 0, function 0. It rejects accesses to targets that cannot exist. It answers the bridge-only header registers from a small local store. It patches the header type and class code on reads, and it moves root-bus accesses onto the bus number that the hardware shares between its root and secondary sides.

Each host access is one request: bus, device, function, 12-bit offset, size (0 = byte, 1 = halfword, 2 = dword), right-aligned write data and a write flag. An access is either answered locally one cycle later, or forwarded to the router. For a forwarded access the router's reply, marked by `fwd_rsp_valid`, is turned into the host response one cycle after it arrives. Only one access is outstanding at a time, and accesses are naturally aligned. When software writes the secondary bus number, the block also drives that number out as the router's local bus number.

Top module: `rp_cfg_shadow`

## Requirements
- R1: On bus 0 any device other than 0 or any function other than 0 is invalid: a read answers all ones at the requested size (0xFF, 0xFFFF, 0xFFFFFFFF), a write answers zero, and nothing is forwarded.
- R2: While `link_up` is low every access to a non-zero bus is invalid and is handled as in R1.
- R3: On the bus equal to the current secondary bus number only device 0 is valid; other devices are handled as in R1.
- R4: On bus 0, offsets 0x10..0x33 and 0x38..0x3B are answered from a local store one cycle after the request and are never forwarded; after reset the word at 0x1C reads 0x00000101 and the word at 0x24 reads 0x00010001, and every other stored word reads zero.
- R5: Any write into the dwords at 0x10, 0x14 or 0x38 leaves that stored dword at zero.
- R6: A local write at offset 0x19 (any size), or a halfword or dword write at 0x18, sets the secondary bus number to bits 15:8 of the merged dword at 0x18, and `local_bus` shows it from the next cycle. A byte write at 0x18 leaves it unchanged.
- R7: A valid bus-0 access outside the local ranges is forwarded one cycle later with bus = secondary bus number, device 1, function 0, and the same offset, size, direction and write data.
- R8: A valid access to a non-zero bus is forwarded with its bus, device, function and offset unchanged, and its read data is returned unpatched.
- R9: On a forwarded bus-0 read that touches dword 0x0C, bits 22:16 of the dword (the low seven bits of byte 0x0E) read as 0x01, and bit 23 is kept.
- R10: On a forwarded bus-0 read that touches dword 0x08, bits 31:8 read as 0x060400, and the revision byte is kept.
- R11: Local byte and halfword accesses use byte lane offset[1:0]: writes merge only the addressed bytes, and reads return the addressed bytes right-aligned.
- R12: Reset clears `local_bus` to 0, drops `rsp_valid` and `fwd_valid`, and restores the local store to its R4 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| req_wdata | input | 32 | Right-aligned write data |
| link_up | input | 1 | Link status from the port |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded direction |
| fwd_bus | output | 8 | Forwarded bus |
| fwd_dev | output | 5 | Forwarded device |
| fwd_func | output | 3 | Forwarded function |
| fwd_off | output | 12 | Forwarded offset |
| fwd_size | output | 2 | Forwarded size |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rsp_valid | input | 1 | Router completion strobe |
| fwd_rsp_rdata | input | 32 | Router read data, right-aligned |
| rsp_valid | output | 1 | Host completion strobe |
| rsp_rdata | output | 32 | Host read data, right-aligned |
| local_bus | output | 8 | Local bus number for the router |

## Verification
The hardest cases to reach are the patches on forwarded reads. They only show up when the bench, acting as the router, returns data that was chosen on purpose to be non-conforming. That data includes a header-type byte with bit 7 set and stray low bits, and a class code of a memory controller. These are returned at byte lanes other than 0, so the lane shift around the patch is exercised as well. A second hard case is the secondary-bus side effect, which depends on how a write lands relative to 0x18 and 0x19. The stimulus therefore walks dword, byte-at-0x19 and byte-at-0x18 writes in sequence. It then aims accesses at the new bus number, to confirm the remap and the device-0 rule on that bus.

// File: rtl/rp_cfg_pkg.sv
package rp_cfg_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word, input logic [1:0] lane,
                                            input logic [1:0] sz);
    lane_pick = (word >> {lane, 3'b000}) & size_mask(sz);
  endfunction
endpackage

// File: rtl/rp_addr_check.sv
module rp_addr_check #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 12,
  parameter int BRIDGE_DEV = 1,
  parameter int IDX_W = 4
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off,
  input  logic             link_up,
  input  logic [BUS_W-1:0] sec_bus,
  output logic             ok,
  output logic             local_hit,
  output logic [IDX_W-1:0] local_idx,
  output logic [BUS_W-1:0] tgt_bus,
  output logic [DEV_W-1:0] tgt_dev,
  output logic [FN_W-1:0]  tgt_fn,
  output logic             hdr_dw,
  output logic             cls_dw
);
  localparam int DWA_W = OFF_W - 2;
  logic root;
  logic [DWA_W-1:0] dwa;

  always_comb begin
    root = (bus == '0);
    dwa  = off[OFF_W-1:2];
    ok = 1'b1;
    if (root && (dev != '0 || fn != '0)) ok = 1'b0;
    if (!root && !link_up) ok = 1'b0;
    if (bus == sec_bus && dev != '0) ok = 1'b0;
    local_hit = root && ((dwa >= DWA_W'(4) && dwa <= DWA_W'(12)) || dwa == DWA_W'(14));
    local_idx = (dwa == DWA_W'(14)) ? IDX_W'(9) : IDX_W'(dwa - DWA_W'(4));
    tgt_bus = root ? sec_bus : bus;
    tgt_dev = root ? DEV_W'(BRIDGE_DEV) : dev;
    tgt_fn  = root ? '0 : fn;
    hdr_dw  = root && dwa == DWA_W'(3);
    cls_dw  = root && dwa == DWA_W'(2);
  end
endmodule

// File: rtl/rp_shadow_store.sv
module rp_shadow_store
  import rp_cfg_pkg::*;
#(
  parameter int WORDS = 10,
  parameter int IDX_W = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [1:0]       lane,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  output logic [31:0]      rword,
  output logic             sec_upd,
  output logic [BUS_W-1:0] sec_val
);
  localparam logic [IDX_W-1:0] IDX_IO   = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_PF   = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_BUSN = IDX_W'(2);

  logic [31:0] mem [WORDS];
  logic [31:0] merged, lmask, stored;
  logic        bar_slot;

  assign rword = mem[idx];

  always_comb begin
    lmask    = size_mask(size) << {lane, 3'b000};
    merged   = (mem[idx] & ~lmask) | ((wdata << {lane, 3'b000}) & lmask);
    bar_slot = (idx == IDX_W'(0)) || (idx == IDX_W'(1)) || (idx == IDX_W'(9));
    stored   = bar_slot ? 32'h0 : merged;
    sec_upd  = wr_en && idx == IDX_BUSN &&
               (lane == 2'd1 || (lane == 2'd0 && size != SZ_BYTE));
    sec_val  = merged[8 +: BUS_W];
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        if (IDX_W'(g) == IDX_IO)      mem[g] <= 32'h0000_0101;
        else if (IDX_W'(g) == IDX_PF) mem[g] <= 32'h0001_0001;
        else                          mem[g] <= 32'h0;
      end else if (wr_en && idx == IDX_W'(g)) begin
        mem[g] <= stored;
      end
    end
  end
endmodule

// File: rtl/rp_rsp_patch.sv
module rp_rsp_patch
  import rp_cfg_pkg::*;
#(
  parameter logic [6:0]  HDR_TYPE = 7'h01,
  parameter logic [23:0] CLASS    = 24'h060400
) (
  input  logic [31:0] raw,
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  input  logic        hdr_dw,
  input  logic        cls_dw,
  output logic [31:0] fixed
);
  logic [31:0] w;
  always_comb begin
    w = (raw & size_mask(size)) << {lane, 3'b000};
    if (hdr_dw) w[22:16] = HDR_TYPE;
    if (cls_dw) w[31:8]  = CLASS;
    fixed = lane_pick(w, lane, size);
  end
endmodule

// File: rtl/rp_cfg_shadow.sv
module rp_cfg_shadow
  import rp_cfg_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 12,
  parameter int BRIDGE_DEV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_func,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             link_up,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic [BUS_W-1:0] fwd_bus,
  output logic [DEV_W-1:0] fwd_dev,
  output logic [FN_W-1:0]  fwd_func,
  output logic [OFF_W-1:0] fwd_off,
  output logic [1:0]       fwd_size,
  output logic [31:0]      fwd_wdata,
  input  logic             fwd_rsp_valid,
  input  logic [31:0]      fwd_rsp_rdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic [BUS_W-1:0] local_bus
);
  localparam int WORDS = 10;
  localparam int IDX_W = $clog2(WORDS);

  logic             ok, local_hit, hdr_dw, cls_dw, sec_upd;
  logic [IDX_W-1:0] local_idx;
  logic [BUS_W-1:0] tgt_bus, sec_val;
  logic [DEV_W-1:0] tgt_dev;
  logic [FN_W-1:0]  tgt_fn;
  logic [31:0]      sh_word, patched;
  logic             p_wr, p_hdr, p_cls;
  logic [1:0]       p_lane, p_size;

  rp_addr_check #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
                  .BRIDGE_DEV(BRIDGE_DEV), .IDX_W(IDX_W)) u_chk_addr (
    .bus(req_bus), .dev(req_dev), .fn(req_func), .off(req_off), .link_up(link_up),
    .sec_bus(local_bus), .ok(ok), .local_hit(local_hit), .local_idx(local_idx),
    .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn), .hdr_dw(hdr_dw), .cls_dw(cls_dw));

  rp_shadow_store #(.WORDS(WORDS), .IDX_W(IDX_W), .BUS_W(BUS_W)) u_store (
    .clk(clk), .rst(rst), .idx(local_idx),
    .wr_en(req_valid && req_write && ok && local_hit),
    .lane(req_off[1:0]), .size(req_size), .wdata(req_wdata),
    .rword(sh_word), .sec_upd(sec_upd), .sec_val(sec_val));

  rp_rsp_patch u_patch (
    .raw(fwd_rsp_rdata), .lane(p_lane), .size(p_size),
    .hdr_dw(p_hdr), .cls_dw(p_cls), .fixed(patched));

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0; rsp_valid <= 1'b0; local_bus <= '0;
      fwd_write <= 1'b0; fwd_bus <= '0; fwd_dev <= '0; fwd_func <= '0;
      fwd_off <= '0; fwd_size <= '0; fwd_wdata <= '0; rsp_rdata <= '0;
      p_wr <= 1'b0; p_hdr <= 1'b0; p_cls <= 1'b0; p_lane <= '0; p_size <= '0;
    end else begin
      fwd_valid <= 1'b0;
      rsp_valid <= 1'b0;
      if (sec_upd) local_bus <= sec_val;
      if (req_valid) begin
        if (!ok) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= req_write ? 32'h0 : size_mask(req_size);
        end else if (local_hit) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= req_write ? 32'h0 : lane_pick(sh_word, req_off[1:0], req_size);
        end else begin
          fwd_valid <= 1'b1;
          fwd_write <= req_write;
          fwd_bus   <= tgt_bus;
          fwd_dev   <= tgt_dev;
          fwd_func  <= tgt_fn;
          fwd_off   <= req_off;
          fwd_size  <= req_size;
          fwd_wdata <= req_wdata;
          p_wr      <= req_write;
          p_hdr     <= hdr_dw;
          p_cls     <= cls_dw;
          p_lane    <= req_off[1:0];
          p_size    <= req_size;
        end
      end
      if (fwd_rsp_valid) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= p_wr ? 32'h0 : patched;
      end
    end
  end
endmodule

// File: rtl/rp_cfg_shadow_chk.sv
module rp_cfg_shadow_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_bus,
  input logic [4:0]  req_dev,
  input logic [2:0]  req_func,
  input logic [11:0] req_off,
  input logic [1:0]  req_size,
  input logic        link_up,
  input logic        fwd_valid,
  input logic [7:0]  fwd_bus,
  input logic [4:0]  fwd_dev,
  input logic [2:0]  fwd_func,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [7:0]  local_bus
);
  logic in_local;
  assign in_local = (req_off >= 12'h010 && req_off <= 12'h033) ||
                    (req_off >= 12'h038 && req_off <= 12'h03B);

  a_r1_bad_root_target: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_bus == 8'd0 && (req_dev != 5'd0 || req_func != 3'd0) |=>
      rsp_valid && !fwd_valid &&
      rsp_rdata == (($past(req_size) == 2'd0) ? 32'hFF :
                    ($past(req_size) == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF));

  a_r2_link_down_blocks: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_bus != 8'd0 && !link_up |=> !fwd_valid && rsp_valid);

  a_r4_local_never_fwd: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_bus == 8'd0 && in_local |=> !fwd_valid && rsp_valid);

  a_r6_bus_only_on_root_write: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && req_bus == 8'd0) |=> $stable(local_bus));

  a_r7_root_remap: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_bus == 8'd0 && req_dev == 5'd0 && req_func == 3'd0 && !in_local |=>
      fwd_valid && fwd_bus == $past(local_bus) && fwd_dev == 5'd1 && fwd_func == 3'd0);

  a_r12_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_valid, fwd_valid}));
endmodule

bind rp_cfg_shadow rp_cfg_shadow_chk u_cfg_chk (.*);

// File: tb/rp_cfg_shadow_tb_top.sv
module rp_cfg_shadow_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, link_up = 1;
  logic [7:0] req_bus = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_func = 0;
  logic [11:0] req_off = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic fwd_valid, fwd_write;
  logic [7:0] fwd_bus;
  logic [4:0] fwd_dev;
  logic [2:0] fwd_func;
  logic [11:0] fwd_off;
  logic [1:0] fwd_size;
  logic [31:0] fwd_wdata;
  logic fwd_rsp_valid = 0;
  logic [31:0] fwd_rsp_rdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0] local_bus;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rp_cfg_shadow dut_i (.*);

  typedef struct packed {
    logic [3:0]  tag;
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        link;
    logic [31:0] rtn;
    logic        xfwd;
    logic [7:0]  xbus;
    logic [4:0]  xdev;
    logic [31:0] xrd;
    logic [7:0]  xlbus;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    // R4 reset contents of the local store
    '{4'd4, 1'b0, 8'd0, 5'd0, 3'd0, 12'h01C, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0000_0101, 8'd0},
    // R11 halfword read of the prefetch word
    '{4'd11,1'b0, 8'd0, 5'd0, 3'd0, 12'h024, 2'd1, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0000_0001, 8'd0},
    // R1 wrong device and function on bus 0
    '{4'd1, 1'b0, 8'd0, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'hFFFF_FFFF, 8'd0},
    '{4'd1, 1'b0, 8'd0, 5'd0, 3'd2, 12'h000, 2'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0000_00FF, 8'd0},
    '{4'd1, 1'b1, 8'd0, 5'd4, 3'd0, 12'h004, 2'd1, 32'h1234, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd0},
    // R6 dword write sets bus 3, byte at 0x19 sets 7, byte at 0x18 keeps 7
    '{4'd6, 1'b1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0005_0300, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd3},
    '{4'd6, 1'b0, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0005_0300, 8'd3},
    '{4'd6, 1'b1, 8'd0, 5'd0, 3'd0, 12'h019, 2'd0, 32'h0000_0007, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd6, 1'b1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd0, 32'h0000_0022, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd11,1'b0, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0005_0722, 8'd7},
    '{4'd11,1'b0, 8'd0, 5'd0, 3'd0, 12'h01A, 2'd0, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0000_0005, 8'd7},
    // R5 BAR and ROM dwords stay zero
    '{4'd5, 1'b1, 8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 32'hFFFF_FFFF, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd5, 1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd5, 1'b1, 8'd0, 5'd0, 3'd0, 12'h03A, 2'd1, 32'h0000_ABCD, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd5, 1'b0, 8'd0, 5'd0, 3'd0, 12'h038, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    // R11 halfword merge at lane 2
    '{4'd11,1'b1, 8'd0, 5'd0, 3'd0, 12'h022, 2'd1, 32'h0000_BEEF, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0, 8'd7},
    '{4'd11,1'b0, 8'd0, 5'd0, 3'd0, 12'h020, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'hBEEF_0000, 8'd7},
    // R9 header type patch, dword and byte 0x0E
    '{4'd9, 1'b0, 8'd0, 5'd0, 3'd0, 12'h00C, 2'd2, 32'h0, 1'b1, 32'h0080_0010, 1'b1, 8'd7, 5'd1, 32'h0081_0010, 8'd7},
    '{4'd9, 1'b0, 8'd0, 5'd0, 3'd0, 12'h00E, 2'd0, 32'h0, 1'b1, 32'h0000_007F, 1'b1, 8'd7, 5'd1, 32'h0000_0001, 8'd7},
    // R10 class code patch, dword and byte 0x0B
    '{4'd10,1'b0, 8'd0, 5'd0, 3'd0, 12'h008, 2'd2, 32'h0, 1'b1, 32'h5080_0002, 1'b1, 8'd7, 5'd1, 32'h0604_0002, 8'd7},
    '{4'd10,1'b0, 8'd0, 5'd0, 3'd0, 12'h00B, 2'd0, 32'h0, 1'b1, 32'h0000_0005, 1'b1, 8'd7, 5'd1, 32'h0000_0006, 8'd7},
    // R8 secondary bus device 0 passes unpatched; R3 other device invalid
    '{4'd8, 1'b0, 8'd7, 5'd0, 3'd0, 12'h00C, 2'd2, 32'h0, 1'b1, 32'h0000_0000, 1'b1, 8'd7, 5'd0, 32'h0000_0000, 8'd7},
    '{4'd3, 1'b0, 8'd7, 5'd3, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0, 8'd0, 5'd0, 32'hFFFF_FFFF, 8'd7},
    '{4'd8, 1'b0, 8'd9, 5'd3, 3'd0, 12'h000, 2'd2, 32'h0, 1'b1, 32'h1122_3344, 1'b1, 8'd9, 5'd3, 32'h1122_3344, 8'd7},
    // R2 link down on a non-zero bus
    '{4'd2, 1'b0, 8'd9, 5'd0, 3'd0, 12'h000, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 8'd0, 5'd0, 32'h0000_FFFF, 8'd7}
  };

  task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v, output bit got_fwd, output bit got_rsp,
                        output logic [31:0] rd, output logic [7:0] fb, output logic [4:0] fd,
                        output logic [2:0] ff, output logic [11:0] fo, output logic fw,
                        output logic [31:0] fwd_d);
    got_fwd = 0; got_rsp = 0; rd = 'x; fb = 'x; fd = 'x; ff = 'x; fo = 'x; fw = 'x; fwd_d = 'x;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_bus = v.bus; req_dev = v.dev; req_func = v.fn;
    req_off = v.off; req_size = v.sz; req_wdata = v.wd; link_up = v.link;
    @(negedge clk);
    req_valid = 0;
    for (int n = 0; n < 8 && !got_rsp; n++) begin
      if (fwd_valid) begin
        got_fwd = 1; fb = fwd_bus; fd = fwd_dev; ff = fwd_func; fo = fwd_off;
        fw = fwd_write; fwd_d = fwd_wdata;
        fwd_rsp_valid = 1; fwd_rsp_rdata = v.rtn;
        @(negedge clk);
        fwd_rsp_valid = 0;
      end else if (rsp_valid) begin
        got_rsp = 1; rd = rsp_rdata;
      end else begin
        @(negedge clk);
      end
    end
    link_up = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=0x%08h expected=0x%08h", 1, 0);
    finish_run();
  end

  initial begin
    bit gf, gr;
    logic [31:0] rd, fdat;
    logic [7:0] fb;
    logic [4:0] fd;
    logic [2:0] ff;
    logic [11:0] fo;
    logic fw;
    vec_t w;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(12, "local_bus in reset", {24'h0, local_bus}, 32'h0);
    chk(12, "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    chk(12, "fwd_valid in reset", {31'h0, fwd_valid}, 32'h0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i], gf, gr, rd, fb, fd, ff, fo, fw, fdat);
      chk(VEC[i].tag, $sformatf("v%0d forwarded", i), {31'h0, gf}, {31'h0, VEC[i].xfwd});
      chk(VEC[i].tag, $sformatf("v%0d completed", i), {31'h0, gr}, 32'h1);
      if (VEC[i].xfwd && gf) begin
        chk(VEC[i].tag, $sformatf("v%0d fwd bus", i), {24'h0, fb}, {24'h0, VEC[i].xbus});
        chk(VEC[i].tag, $sformatf("v%0d fwd dev", i), {27'h0, fd}, {27'h0, VEC[i].xdev});
        chk(VEC[i].tag, $sformatf("v%0d fwd func", i), {29'h0, ff}, (VEC[i].bus == 0) ? 32'h0 : {29'h0, VEC[i].fn});
        chk(VEC[i].tag, $sformatf("v%0d fwd off", i), {20'h0, fo}, {20'h0, VEC[i].off});
      end
      chk(VEC[i].tag, $sformatf("v%0d rdata", i), rd, VEC[i].wr ? 32'h0 : VEC[i].xrd);
      chk(VEC[i].tag, $sformatf("v%0d local_bus", i), {24'h0, local_bus}, {24'h0, VEC[i].xlbus});
    end

    // R7 forwarded root write keeps offset, size, direction and data
    w = VEC[0];
    w.wr = 1; w.off = 12'h004; w.sz = 2'd1; w.wd = 32'h0000_0146;
    access(w, gf, gr, rd, fb, fd, ff, fo, fw, fdat);
    chk(7, "root write forwarded", {31'h0, gf}, 32'h1);
    chk(7, "root write bus", {24'h0, fb}, 32'd7);
    chk(7, "root write dev", {27'h0, fd}, 32'd1);
    chk(7, "root write dir", {31'h0, fw}, 32'h1);
    chk(7, "root write data", fdat, 32'h0000_0146);

    // R2 write with link down is dropped
    w.bus = 8'd9; w.dev = 0; w.link = 0;
    access(w, gf, gr, rd, fb, fd, ff, fo, fw, fdat);
    chk(2, "link-down write forwarded", {31'h0, gf}, 32'h0);

    // R12 reset restores the store and the bus number
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    chk(12, "local_bus after reset", {24'h0, local_bus}, 32'h0);
    w = VEC[0];
    access(w, gf, gr, rd, fb, fd, ff, fo, fw, fdat);
    chk(12, "io word after reset", rd, 32'h0000_0101);
    w.off = 12'h018;
    access(w, gf, gr, rd, fb, fd, ff, fo, fw, fdat);
    chk(12, "bus word after reset", rd, 32'h0);
    w.off = 12'h020;
    access(w, gf, gr, rd, fb, fd, ff, fo, fw, fdat);
    chk(12, "lane word after reset", rd, 32'h0);

    finish_run();
  end
endmodule